// File: doc/BRIEF.md
# Reloadable Baud Rate Down-Counter

This block paces the shift clock of a synchronous serial port. A down-counter is advanced once every two system clocks and is reloaded from a programmable 16-bit value each time it passes zero. The resulting bit rate is f_sys / (2 × (reload + 1)), with the reload value taken as unsigned. On every reload the block sends a single-cycle baud tick to the shift logic.

One register slot, reached by plain read and write strobes with no address, serves two roles. While the port enable is low, the slot holds the reload value and can be written and read back. While the enable is high, a read returns the live count, and any write is dropped. Clearing the enable stops the count. Setting it again restarts the count from the reload value.

Top module: `baud_divider`

## Requirements
- R1: After reset the reload value is 0x0000, the tick is low, and a read returns 0x0000.
- R2: A write strobe while the enable is low stores the write data as the reload value, and a read while the enable is low returns it in the same cycle.
- R3: A write strobe while the enable is high has no effect: after the enable is cleared, a read returns the reload value written before enabling, and tick timing is unchanged.
- R4: While enabled, a read returns the live count. The count equals the reload value in the first cycle after the enable is sampled, and drops by one every second system clock.
- R5: Ticks repeat every 2 × (reload + 1) system clocks, and each tick is exactly one system clock wide.
- R6: The first tick appears 2 × reload + 2 clock edges after the edge at which the enable is first sampled high.
- R7: With a reload value of 0, a tick is emitted every 2 system clocks.
- R8: Clearing the enable stops counting and ticks. Setting it again restarts the count from the full reload value, with the R6 first-tick delay.
- R9: All 16 reload bits take effect. A reload of 0x0100 gives a tick period of 514 clocks.
- R10: When the read strobe is low, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global port enable; counting runs while high |
| wr_stb | input | 1 | Register write strobe |
| wdata | input | W | Write data (reload value) |
| rd_stb | input | 1 | Register read strobe |
| rdata | output | W | Read data: reload value when disabled, live count when enabled |
| tick | output | 1 | One-clock baud tick, emitted at each reload |

## Verification
Reload values from 0 through 20 are each run for three full periods. Every cycle of each run is compared against an arithmetic model, which separates an off-by-one in the prescaler from one in the count. Reload 0 covers the degenerate period of 2. Reload 0x0100 shows that the upper byte is decoded. Throughout every run the write strobe is held high with different data, so any leak of a write while enabled shows up in the read-back after disabling. A run that is stopped mid-count and then re-enabled separates a frozen restart from a fresh one.

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  input  logic         rd_stb,
  output logic [W-1:0] rdata,
  output logic         tick
);

  logic [W-1:0] reload_q;
  logic [W-1:0] cnt_q;
  logic         en_q;
  logic         ph_q;
  logic         run;

  assign run   = en & en_q;
  assign rdata = rd_stb ? (run ? cnt_q : reload_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload_q <= '0;
    else if (wr_stb && !en) reload_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ph_q  <= 1'b0;
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      en_q <= en;
      tick <= 1'b0;
      if (!en) begin
        ph_q <= 1'b0;
      end else if (!en_q) begin
        cnt_q <= reload_q;
        ph_q  <= 1'b0;
      end else begin
        ph_q <= ~ph_q;
        if (ph_q) begin
          if (cnt_q == '0) begin
            cnt_q <= reload_q;
            tick  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - W'(1);
          end
        end
      end
    end
  end

  // R5
  tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3
  wr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && en) |=> $stable(reload_q));

  // R8
  tick_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(en));

  // R5
  tick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt_q == reload_q));

  // R4
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ph_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: tb/baud_divider_tb_top.sv
module baud_divider_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic         wr_stb = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         rd_stb = 1'b0;
  logic [W-1:0] rdata;
  logic         tick;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  baud_divider #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_stb(wr_stb), .wdata(wdata),
    .rd_stb(rd_stb), .rdata(rdata), .tick(tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int r);
    @(negedge clk);
    en = 1'b0; wr_stb = 1'b1; wdata = W'(r); rd_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    chk("R2 readback", int'(rdata), r);
  endtask

  task automatic run(input int r, input int nper, input int stop_at);
    int period;
    int c;
    period = 2 * r + 2;
    wr_stb = 1'b1; wdata = W'(r) ^ 16'h5A5A; rd_stb = 1'b1; en = 1'b1;
    @(posedge clk);
    c = 0;
    while (c <= nper * period && c != stop_at) begin
      @(negedge clk);
      chk(r == 0 ? "R7 tick" : (c == period ? "R6 tick" : (r == 256 ? "R9 tick" : "R5 tick")),
          int'(tick), (c > 0 && c % period == 0) ? 1 : 0);
      chk("R4 count", int'(rdata), r - (c % period) / 2);
      @(posedge clk);
      c++;
    end
    @(negedge clk);
    en = 1'b0; wr_stb = 1'b0;
    #1 chk("R3 reload kept", int'(rdata), r);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd_stb = 1'b1;
    #1;
    chk("R1 read", int'(rdata), 0);
    chk("R1 tick", int'(tick), 0);
    rd_stb = 1'b0;
    wr_stb = 1'b1; wdata = 16'h1234;
    @(negedge clk);
    wr_stb = 1'b0;
    chk("R10 idle rdata", int'(rdata), 0);

    for (int r = 0; r <= 20; r++) begin
      load(r);
      run(r, 3, -1);
    end

    load(5);
    run(5, 3, 7);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R8 stopped tick", int'(tick), 0);
    end
    run(5, 1, -1);

    load(256);
    run(256, 2, -1);

    rd_stb = 1'b0;
    @(negedge clk);
    chk("R10 idle rdata", int'(rdata), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule